// File: doc/BRIEF.md
# High-Speed Receive Enable Sequencer

This block brings up the high-speed receive path of a camera-serial receiver that has three clock-lane ports, each with its own group of data lanes. For every port it produces three enables in a fixed chain. First comes the termination enable. The clock-lane and data-lane high-speed enables follow it after programmable delays. The clock-ungate signal comes last and releases the gated receive clocks once the clock-lane enable has been up for a third programmable delay.

All timing comes from one 32-bit control word. An upstream register supplies it unchanged. A one-cycle `tick` pulse marks each 2 ns unit of delay time. Each port also has a 2-bit mode field in the control word, which picks where termination comes from:
- the PHY's own termination request, with the receive clocks gated during bring-up;
- a forced-on setting;
- a small detector that watches the sampled low-power line states;
- the PHY request with clock gating bypassed.

Top module: `hs_bringup_seq`

## Requirements
- R1: In mode 00 and mode 11, `term_en[i]` equals `phy_term_en[i]` in the same cycle. The mode of port i sits in control bits [17+2i:16+2i].
- R2: In mode 01, `term_en[i]`, `clk_hs_en[i]` and `data_hs_en[i]` are all high, whatever the PHY request and line states are.
- R3: In mode 10, `term_en[i]` rises one clock after the lines are sampled at LP-00 (`lp_p`=0, `lp_n`=0), but only if the sample before that was LP-01 (`lp_p`=0, `lp_n`=1). It falls one clock after either line is sampled high. Going from LP-11 straight to LP-00 does not raise it.
- R4: `clk_hs_en[i]` rises exactly N tick-cycles after `term_en[i]` rises, where N is control bits [15:8]. When N=0 it rises in the same cycle.
- R5: `data_hs_en[i]` rises exactly N tick-cycles after `term_en[i]` rises, where N is control bits [7:0]. When N=0 it rises in the same cycle.
- R6: In modes 00, 01 and 10, `clk_ungate[i]` rises exactly N tick-cycles after `clk_hs_en[i]` rises, where N is control bits [31:24]. In mode 11 it is held high.
- R7: A delay counts only the cycles in which `tick` is high. While `tick` is low, a pending enable stays low.
- R8: When `term_en[i]` falls in modes 00 and 10, `clk_hs_en[i]`, `data_hs_en[i]` and `clk_ungate[i]` fall in the same cycle. A later rise of termination waits out the full delay again.
- R9: Control bits [23:22] have no effect on any output.
- R10: The ports are independent. Sequencing one port leaves every output of the idle ports low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per 2 ns delay unit |
| ctrl_word | input | 32 | Delay fields and per-port mode fields |
| phy_term_en | input | NUM_LANES | Termination request from the PHY, one per port |
| lp_p | input | NUM_LANES | Sampled low-power state of the positive clock line |
| lp_n | input | NUM_LANES | Sampled low-power state of the negative clock line |
| term_en | output | NUM_LANES | High-speed termination enable |
| clk_hs_en | output | NUM_LANES | Clock-lane high-speed enable |
| data_hs_en | output | NUM_LANES | Data-lane high-speed enable |
| clk_ungate | output | NUM_LANES | Release of the gated high-speed clocks |

## Verification
The bench builds the block with its default of three ports and the fixed 8-bit delay fields. This small configuration lets it sweep every mode on every port against five delay sets: the power-up values (10, 0, 100), all zeros, all at the 255 maximum, and two mixed small sets. It therefore reaches the zero-delay same-cycle case and the full 510-unit chained ungate in every mode. With tick held high, each expected rise cycle is plain arithmetic: the sum of the delays on the path, plus one cycle for the line detector in mode 10.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

   localparam int DLY_W      = 8;
   localparam int MAX_LANES  = 3;
   localparam int DATA_LSB   = 0;
   localparam int CLK_LSB    = 8;
   localparam int MODE_LSB   = 16;
   localparam int MODE_W     = 2;
   localparam int RSV_LSB    = 22;
   localparam int UNGATE_LSB = 24;

   typedef enum logic [1:0] {
      TERM_PHY_GATED = 2'b00,
      TERM_FORCE_ON  = 2'b01,
      TERM_LINE_SENSE = 2'b10,
      TERM_PHY_FREE  = 2'b11
   } term_mode_e;

   typedef enum logic [1:0] {
      LS_WAIT01 = 2'b00,
      LS_SAW01  = 2'b01,
      LS_ON     = 2'b10
   } line_state_e;

endpackage

// File: rtl/hsq_delay_stage.sv
module hsq_delay_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         start,
   input  logic [W-1:0] delay,
   output logic         done
);

   if (W < 1) begin : g_bad_width
      $error("hsq_delay_stage: W must be at least 1");
   end

   logic         loaded;
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         cnt    <= '0;
      end else if (!start) begin
         loaded <= 1'b0;
         cnt    <= '0;
      end else if (!loaded) begin
         loaded <= 1'b1;
         cnt    <= (tick && delay != '0) ? delay - W'(1) : delay;
      end else if (tick && cnt != '0) begin
         cnt <= cnt - W'(1);
      end
   end

   assign done = start && (loaded ? (cnt == '0) : (delay == '0));

   // R7: a loaded count does not move while tick is low
   p_hold_without_tick_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (start && loaded && !tick) |=> (!start || cnt == $past(cnt)));

   // R4: a fresh start with a nonzero delay is never done at once
   p_no_early_done_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start) && delay != '0) |-> !done);

endmodule

// File: rtl/hsq_line_sense.sv
module hsq_line_sense
   import hsq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lp_p,
   input  logic lp_n,
   output logic term
);

   line_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      if (!en) begin
         state_nx = LS_WAIT01;
      end else begin
         unique case (state)
            LS_WAIT01: if (!lp_p && lp_n) state_nx = LS_SAW01;
            LS_SAW01: begin
               if (!lp_p && !lp_n) state_nx = LS_ON;
               else if (lp_p)      state_nx = LS_WAIT01;
            end
            LS_ON:     if (lp_p || lp_n) state_nx = LS_WAIT01;
            default:   state_nx = LS_WAIT01;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LS_WAIT01;
      else        state <= state_nx;
   end

   assign term = (state == LS_ON);

   // R3: termination only rises after an LP-00 sample
   p_rise_after_lp00_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(term) |-> $past(!lp_p && !lp_n));

   // R3: any line high ends termination on the next clock
   p_drop_on_line_high_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && term && (lp_p || lp_n)) |=> !term);

endmodule

// File: rtl/hsq_lane.sv
module hsq_lane
   import hsq_pkg::*;
#(
   parameter int W = DLY_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  term_mode_e   mode,
   input  logic [W-1:0] clk_dly,
   input  logic [W-1:0] data_dly,
   input  logic [W-1:0] ungate_dly,
   input  logic         phy_term,
   input  logic         lp_p,
   input  logic         lp_n,
   output logic         term_en,
   output logic         clk_hs_en,
   output logic         data_hs_en,
   output logic         clk_ungate
);

   logic sense_term;
   logic clk_done, data_done, ungate_done;
   logic forced;

   assign forced = (mode == TERM_FORCE_ON);

   hsq_line_sense u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode == TERM_LINE_SENSE),
      .lp_p  (lp_p),
      .lp_n  (lp_n),
      .term  (sense_term)
   );

   always_comb begin
      unique case (mode)
         TERM_FORCE_ON:   term_en = 1'b1;
         TERM_LINE_SENSE: term_en = sense_term;
         default:         term_en = phy_term;
      endcase
   end

   hsq_delay_stage #(.W(W)) u_clk_stage (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .start (term_en), .delay (clk_dly), .done (clk_done)
   );

   hsq_delay_stage #(.W(W)) u_data_stage (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .start (term_en), .delay (data_dly), .done (data_done)
   );

   assign clk_hs_en  = forced || clk_done;
   assign data_hs_en = forced || data_done;

   hsq_delay_stage #(.W(W)) u_ungate_stage (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .start (clk_hs_en), .delay (ungate_dly), .done (ungate_done)
   );

   assign clk_ungate = (mode == TERM_PHY_FREE) || ungate_done;

   // R8: no high-speed enable without termination
   p_hs_needs_term_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_hs_en || data_hs_en) |-> term_en);

   // R6: clocks are released only behind the clock-lane enable, except when gating is bypassed
   p_ungate_needs_hs_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode != TERM_PHY_FREE && clk_ungate) |-> clk_hs_en);

   // R2: the forced mode holds every enable of the chain head
   p_forced_all_on_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TERM_FORCE_ON) |-> (term_en && clk_hs_en && data_hs_en));

endmodule

// File: rtl/hs_bringup_seq.sv
module hs_bringup_seq
   import hsq_pkg::*;
#(
   parameter int NUM_LANES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [31:0]          ctrl_word,
   input  logic [NUM_LANES-1:0] phy_term_en,
   input  logic [NUM_LANES-1:0] lp_p,
   input  logic [NUM_LANES-1:0] lp_n,
   output logic [NUM_LANES-1:0] term_en,
   output logic [NUM_LANES-1:0] clk_hs_en,
   output logic [NUM_LANES-1:0] data_hs_en,
   output logic [NUM_LANES-1:0] clk_ungate
);

   localparam int MODE_TOP = MODE_LSB + MODE_W * NUM_LANES;

   if (NUM_LANES < 1 || NUM_LANES > MAX_LANES) begin : g_bad_lanes
      $error("hs_bringup_seq: NUM_LANES must lie in 1..3");
   end
   if (MODE_TOP > RSV_LSB) begin : g_bad_layout
      $error("hs_bringup_seq: mode fields overrun the reserved bits");
   end

   logic [DLY_W-1:0] clk_dly, data_dly, ungate_dly;
   logic             unused_rsv_bits;

   assign clk_dly         = ctrl_word[CLK_LSB    +: DLY_W];
   assign data_dly        = ctrl_word[DATA_LSB   +: DLY_W];
   assign ungate_dly      = ctrl_word[UNGATE_LSB +: DLY_W];
   assign unused_rsv_bits = ^ctrl_word[RSV_LSB +: 2];

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      term_mode_e mode;
      assign mode = term_mode_e'(ctrl_word[MODE_LSB + MODE_W*i +: MODE_W]);

      hsq_lane #(.W(DLY_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .mode       (mode),
         .clk_dly    (clk_dly),
         .data_dly   (data_dly),
         .ungate_dly (ungate_dly),
         .phy_term   (phy_term_en[i]),
         .lp_p       (lp_p[i]),
         .lp_n       (lp_n[i]),
         .term_en    (term_en[i]),
         .clk_hs_en  (clk_hs_en[i]),
         .data_hs_en (data_hs_en[i]),
         .clk_ungate (clk_ungate[i])
      );
   end

   if (MODE_TOP < RSV_LSB) begin : g_spare_modes
      logic unused_mode_bits;
      assign unused_mode_bits = ^ctrl_word[RSV_LSB-1:MODE_TOP];
   end

endmodule

// File: tb/sim_hs_bringup_seq.sv
`timescale 1ns/1ps
module sim_hs_bringup_seq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [31:0] ctrl_word;
   logic [2:0] phy_term_en, lp_p, lp_n;
   logic [2:0] term_en, clk_hs_en, data_hs_en, clk_ungate;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hs_bringup_seq #(.NUM_LANES(3)) u0 (
      .clk (clk), .rst_n (rst_n), .tick (tick), .ctrl_word (ctrl_word),
      .phy_term_en (phy_term_en), .lp_p (lp_p), .lp_n (lp_n),
      .term_en (term_en), .clk_hs_en (clk_hs_en),
      .data_hs_en (data_hs_en), .clk_ungate (clk_ungate)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int du, input int dc, input int dd,
                                      input int lane, input logic [1:0] m, input bit rsv);
      logic [31:0] w;
      w = '0;
      w[31:24] = du[7:0];
      w[15:8]  = dc[7:0];
      w[7:0]   = dd[7:0];
      w[23:22] = rsv ? 2'b11 : 2'b00;
      w[16 + 2*lane +: 2] = m;
      return w;
   endfunction

   // first-rise cycle of each output of one lane; -1 when never seen
   task automatic measure(input int lane, output int tt, output int th,
                          output int td, output int tu);
      tt = -1; th = -1; td = -1; tu = -1;
      for (int c = 0; c <= 600; c++) begin
         #1;
         if (tt < 0 && term_en[lane])    tt = c;
         if (th < 0 && clk_hs_en[lane])  th = c;
         if (td < 0 && data_hs_en[lane]) td = c;
         if (tu < 0 && clk_ungate[lane]) tu = c;
         if (tt >= 0 && th >= 0 && td >= 0 && tu >= 0) break;
         @(negedge clk);
      end
   endtask

   task automatic quiesce(input logic [31:0] w);
      @(negedge clk);
      ctrl_word = w; phy_term_en = '0; lp_p = '1; lp_n = '1; tick = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_vec(input int lane, input logic [1:0] m,
                          input int dc, input int dd, input int du);
      int tt, th, td, tu, off;
      string tr;
      quiesce(mk(du, dc, dd, lane, 2'b00, 1'b0));
      off = 0;
      case (m)
         2'b10: begin
            ctrl_word = mk(du, dc, dd, lane, m, 1'b0);
            lp_p[lane] = 1'b0; lp_n[lane] = 1'b1;
            @(negedge clk);
            lp_n[lane] = 1'b0;
            off = 1; tr = "R3";
         end
         2'b01: begin
            ctrl_word = mk(du, dc, dd, lane, m, 1'b0);
            tr = "R2";
         end
         default: begin
            ctrl_word = mk(du, dc, dd, lane, m, 1'b0);
            phy_term_en[lane] = 1'b1;
            tr = "R1";
         end
      endcase
      measure(lane, tt, th, td, tu);
      chk(tr, $sformatf("term rise m=%0d lane=%0d", m, lane), tt, off);
      chk((m == 2'b01) ? "R2" : "R4", $sformatf("clk hs rise m=%0d dc=%0d", m, dc),
          th, (m == 2'b01) ? 0 : off + dc);
      chk((m == 2'b01) ? "R2" : "R5", $sformatf("data hs rise m=%0d dd=%0d", m, dd),
          td, (m == 2'b01) ? 0 : off + dd);
      chk("R6", $sformatf("ungate rise m=%0d dc=%0d du=%0d", m, dc, du), tu,
          (m == 2'b11) ? 0 : (m == 2'b01) ? du : off + dc + du);
      for (int o = 0; o < 3; o++) begin
         if (o != lane)
            chk("R10", $sformatf("idle lane %0d outputs", o),
                int'({term_en[o], clk_hs_en[o], data_hs_en[o], clk_ungate[o]}), 0);
      end
      if (m == 2'b00) begin
         phy_term_en[lane] = 1'b0;
         #1;
         chk("R8", "drop after phy release",
             int'({term_en[lane], clk_hs_en[lane], data_hs_en[lane], clk_ungate[lane]}), 0);
         @(negedge clk);
         phy_term_en[lane] = 1'b1;
         measure(lane, tt, th, td, tu);
         chk("R8", $sformatf("restart clk hs dc=%0d", dc), th, dc);
      end else if (m == 2'b10) begin
         lp_p[lane] = 1'b1;
         @(negedge clk);
         #1;
         chk("R3", "drop after line high",
             int'({term_en[lane], clk_hs_en[lane], data_hs_en[lane], clk_ungate[lane]}), 0);
      end
   endtask

   initial begin
      int dcs[5] = '{10, 0, 255, 1, 3};
      int dds[5] = '{0, 0, 255, 7, 0};
      int dus[5] = '{100, 0, 255, 2, 1};
      int tt, th, td, tu;
      rst_n = 1'b0; tick = 1'b1; ctrl_word = '0;
      phy_term_en = '0; lp_p = '1; lp_n = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "reset term_en", int'(term_en), 0);
      chk("R6", "reset clk_ungate", int'(clk_ungate), 0);
      chk("R4", "reset clk_hs_en", int'(clk_hs_en), 0);

      for (int m = 0; m < 4; m++)
         for (int lane = 0; lane < 3; lane++)
            for (int s = 0; s < 5; s++)
               run_vec(lane, m[1:0], dcs[s], dds[s], dus[s]);

      // R3: LP-11 straight to LP-00 does not raise termination
      quiesce(mk(0, 0, 0, 1, 2'b10, 1'b0));
      lp_p[1] = 1'b0; lp_n[1] = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      chk("R3", "no term without LP-01", int'(term_en[1]), 0);

      // R7: tick low freezes the count
      quiesce(mk(0, 5, 0, 2, 2'b00, 1'b0));
      tick = 1'b0;
      phy_term_en[2] = 1'b1;
      repeat (20) @(negedge clk);
      #1;
      chk("R7", "clk hs while tick low", int'(clk_hs_en[2]), 0);
      tick = 1'b1;
      measure(2, tt, th, td, tu);
      chk("R7", "clk hs after tick resumes", th, 5);

      // R9: reserved bits set change nothing
      quiesce(mk(4, 3, 2, 0, 2'b00, 1'b1));
      phy_term_en[0] = 1'b1;
      measure(0, tt, th, td, tu);
      chk("R9", "clk hs with reserved set", th, 3);
      chk("R9", "data hs with reserved set", td, 2);
      chk("R9", "ungate with reserved set", tu, 7);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule